// File: doc/BRIEF.md
# Intra-Line Bit Rotation Shifter

This block spreads bit-level wear across the cells of a small non-volatile line store. Every line is written rotated left by a global offset, and every read un-rotates it by the same offset. A given logical bit therefore lands on a different physical cell as the offset moves. A global write counter advances the offset by one position, modulo the line width, after a programmable number of accepted writes.

When the offset advances, a background sweep remaps the whole array. The sweep takes one line per cycle: it un-rotates each line with the old offset and re-rotates it with the new one. The block raises `busy` while the sweep runs. Host writes are dropped during that time, and read data is only meaningful while `busy` is low.

Top module: `bit_rot_store`

## Requirements
- R1: After reset, `curOffset` is 0, `busy` is 0 and the write counter is 0. With a non-zero `intervalLimit`, the first rotation therefore follows exactly `intervalLimit` accepted writes.
- R2: While `busy` is low, `rdData` equals the data most recently written to `rdAddr`.
- R3: The accepted write that brings the counter to `intervalLimit` causes `busy` to be high, sampled after that clock edge, for exactly `DEPTH` cycles. When `busy` falls, `curOffset` has grown by one.
- R4: The offset wraps from `LINE_W-1` back to 0.
- R5: A write presented while `busy` is high is dropped. It neither changes stored data nor counts toward the interval.
- R6: An `intervalLimit` of 0 disables rotation. `busy` stays low and `curOffset` does not change.
- R7: Data stored in every line survives any number of rotations unchanged, as seen on the read port.
- R8: The write counter clears on each rotation, so the next rotation needs another `intervalLimit` accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write request, accepted when `busy` is low |
| wrAddr | input | ADDR_W | Line address of the write |
| wrData | input | LINE_W | Logical line data to write |
| intervalLimit | input | CNT_W | Accepted writes per offset step; 0 disables rotation |
| rdAddr | input | ADDR_W | Line address of the read |
| rdData | output | LINE_W | Logical (un-rotated) line data |
| busy | output | 1 | Remap sweep in progress |
| curOffset | output | OFF_W | Current rotation offset |

## Verification
The bench aims at the write that triggers a rotation. That write must be stored with the old offset and then swept. A design that stored it with the new offset, or counted off by one, would return garbage for that address or rotate one write early or late. The bench also presents writes during a sweep: a design that let them through would corrupt a line the sweep had already remapped, or shift the next rotation. Finally, the offset is driven through its wrap point, and a zero interval is checked to confirm it never starts a sweep.

// File: rtl/bit_rot_pkg.sv
package bit_rot_pkg;
  typedef struct packed {
    logic hostWe;
    logic sweepWe;
  } rotStrobes_t;
endpackage

// File: rtl/bit_rot_ctrl.sv
module bit_rot_ctrl
  import bit_rot_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  localparam int OFF_W  = $clog2(LINE_W),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [CNT_W-1:0]  intervalLimit,
  output rotStrobes_t       strobes,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic [OFF_W-1:0]  offset,
  output logic [OFF_W-1:0]  nextOffset,
  output logic              busy
);
  logic [CNT_W-1:0] writeCnt;
  logic [CNT_W:0]   cntPlusOne;
  logic             sweepActive;
  logic             trigger;
  logic             lastLine;

  assign busy       = sweepActive;
  assign cntPlusOne = {1'b0, writeCnt} + 1'b1;
  assign nextOffset = (offset == OFF_W'(LINE_W - 1)) ? '0 : offset + 1'b1;
  assign lastLine   = (sweepAddr == ADDR_W'(DEPTH - 1));

  always_comb begin
    strobes.hostWe  = wrValid && !sweepActive;
    strobes.sweepWe = sweepActive;
    trigger = strobes.hostWe && (intervalLimit != '0) &&
              (cntPlusOne >= {1'b0, intervalLimit});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeCnt    <= '0;
      sweepActive <= 1'b0;
      sweepAddr   <= '0;
      offset      <= '0;
    end else if (sweepActive) begin
      if (lastLine) begin
        sweepActive <= 1'b0;
        sweepAddr   <= '0;
        offset      <= nextOffset;
      end else begin
        sweepAddr <= sweepAddr + 1'b1;
      end
    end else if (trigger) begin
      writeCnt    <= '0;
      sweepActive <= 1'b1;
      sweepAddr   <= '0;
    end else if (strobes.hostWe && intervalLimit != '0) begin
      writeCnt <= cntPlusOne[CNT_W-1:0];
    end
  end

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (offset != $past(offset)) |->
      (offset == (($past(offset) == OFF_W'(LINE_W - 1)) ? '0 : $past(offset) + 1'b1))) // R4
    else $error("offset moved by other than one step");

  AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(wrValid) && intervalLimit != '0)) // R3
    else $error("sweep started without an accepted write");

  AST_OFFSET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busy) |-> $stable(offset)) // R6
    else $error("offset changed outside a sweep");
endmodule

// File: rtl/bit_rot_datapath.sv
module bit_rot_datapath
  import bit_rot_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int DEPTH  = 8,
  localparam int OFF_W  = $clog2(LINE_W),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rotStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LINE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W-1:0]  nextOffset,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [LINE_W-1:0] rdData
);
  logic [LINE_W-1:0] cells [DEPTH];

  function automatic logic [LINE_W-1:0] rotLeft(input logic [LINE_W-1:0] x,
                                                input logic [OFF_W-1:0] amt);
    logic [2*LINE_W-1:0] dbl;
    dbl = {x, x} << amt;
    return dbl[2*LINE_W-1:LINE_W];
  endfunction

  function automatic logic [LINE_W-1:0] rotRight(input logic [LINE_W-1:0] x,
                                                 input logic [OFF_W-1:0] amt);
    logic [2*LINE_W-1:0] dbl;
    dbl = {x, x} >> amt;
    return dbl[LINE_W-1:0];
  endfunction

  logic [LINE_W-1:0] sweepLogical;
  logic [LINE_W-1:0] sweepPhys;
  logic [LINE_W-1:0] hostPhys;

  assign sweepLogical = rotRight(cells[sweepAddr], offset);
  assign sweepPhys    = rotLeft(sweepLogical, nextOffset);
  assign hostPhys     = rotLeft(wrData, offset);
  assign rdData       = rotRight(cells[rdAddr], offset);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (strobes.sweepWe) begin
      cells[sweepAddr] <= sweepPhys;
    end else if (strobes.hostWe) begin
      cells[wrAddr] <= hostPhys;
    end
  end

  AST_NO_HOST_IN_SWEEP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.hostWe, strobes.sweepWe})) // R5
    else $error("host and sweep write in the same cycle");

  AST_SWEEP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sweepWe |=> ($countones(cells[$past(sweepAddr)]) ==
                         $countones($past(cells[sweepAddr])))) // R7
    else $error("sweep altered the bit count of a line");
endmodule

// File: rtl/bit_rot_store.sv
module bit_rot_store
  import bit_rot_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  localparam int OFF_W  = $clog2(LINE_W),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LINE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  intervalLimit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [LINE_W-1:0] rdData,
  output logic              busy,
  output logic [OFF_W-1:0]  curOffset
);
  rotStrobes_t       strobes;
  logic [ADDR_W-1:0] sweepAddr;
  logic [OFF_W-1:0]  nextOffset;

  bit_rot_ctrl #(.LINE_W(LINE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .intervalLimit(intervalLimit),
    .strobes(strobes), .sweepAddr(sweepAddr), .offset(curOffset),
    .nextOffset(nextOffset), .busy(busy));

  bit_rot_datapath #(.LINE_W(LINE_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .wrData(wrData),
    .sweepAddr(sweepAddr), .offset(curOffset), .nextOffset(nextOffset),
    .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: tb/sim_bit_rot_store.sv
`timescale 1ns/1ps
module sim_bit_rot_store;
  localparam int LINE_W = 16;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = 8;
  localparam int OFF_W  = $clog2(LINE_W);
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [LINE_W-1:0] wrData = '0;
  logic [CNT_W-1:0]  intervalLimit = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [LINE_W-1:0] rdData;
  logic busy;
  logic [OFF_W-1:0] curOffset;

  int checks = 0;
  int failures = 0;
  logic [LINE_W-1:0] model [DEPTH];
  int expOffset = 0;
  int expCnt = 0;

  always #2.5 clk = ~clk;

  bit_rot_store #(.LINE_W(LINE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .intervalLimit(intervalLimit), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .curOffset(curOffset));

  function automatic int nextOff(input int o);
    return (o + 1) % LINE_W;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readCheck(input int addr, input string req);
    @(negedge clk);
    rdAddr = ADDR_W'(addr);
    #0.5;
    check(req, rdData, model[addr]);
  endtask

  // One write; if it triggers a rotation, the sweep is timed and,
  // when junk is set, dropped writes are offered during it.
  task automatic doWrite(input int addr, input logic [LINE_W-1:0] data,
                         input bit junk);
    int n;
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = ADDR_W'(addr);
    wrData  = data;
    @(posedge clk);
    #1;
    wrValid = 1'b0;
    model[addr] = data;
    if (intervalLimit != 0) expCnt++;
    if (intervalLimit != 0 && expCnt >= int'(intervalLimit)) begin
      expCnt = 0;
      check("R3 busy after trigger", busy, 1);
      n = 0;
      while (busy && n < 4 * DEPTH) begin
        if (junk) begin
          wrValid = 1'b1;
          wrAddr  = ADDR_W'(addr);
          wrData  = ~data;
        end
        @(posedge clk);
        #1;
        wrValid = 1'b0;
        n++;
      end
      check("R3 sweep length", n, DEPTH);
      expOffset = nextOff(expOffset);
      check("R3 R4 offset step", curOffset, expOffset);
    end else begin
      check("R6 R8 no sweep", busy, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #12;
    @(negedge clk);
    check("R1 reset offset", curOffset, 0);
    check("R1 reset busy", busy, 0);
    rstN = 1'b1;

    // R6: zero interval never rotates
    intervalLimit = '0;
    for (int i = 0; i < 40; i++) doWrite(i % DEPTH, LINE_W'($urandom), 0);
    check("R6 offset held", curOffset, 0);
    for (int i = 0; i < DEPTH; i++) readCheck(i, "R2 read after writes");

    // R1/R8: exactly limit writes per rotation from reset count
    intervalLimit = 8'd3;
    for (int i = 0; i < 6; i++) doWrite(i, LINE_W'($urandom), 0);
    check("R8 two rotations", curOffset, 2);
    for (int i = 0; i < DEPTH; i++) readCheck(i, "R7 data after rotation");

    // R5: writes during sweep are dropped and not counted
    for (int i = 0; i < 3; i++) doWrite(2, 16'hA5C3 + LINE_W'(i), 1);
    readCheck(2, "R5 dropped write");
    doWrite(4, 16'h1234, 0);
    doWrite(5, 16'h4321, 0);
    check("R5 no extra count", curOffset, 3);
    doWrite(6, 16'h8001, 0);

    // R4: drive the offset through its wrap point
    intervalLimit = 8'd1;
    for (int i = 0; i < LINE_W + 2; i++) doWrite(i % DEPTH, LINE_W'($urandom), 0);
    check("R4 wrapped offset", curOffset, expOffset);
    for (int i = 0; i < DEPTH; i++) readCheck(i, "R7 data after wrap");

    // Random mix of writes, reads and interval values
    for (int k = 0; k < 300; k++) begin
      if (($urandom % 40) == 0) intervalLimit = CNT_W'($urandom % 6);
      if ($urandom % 2) doWrite(int'($urandom % DEPTH), LINE_W'($urandom), ($urandom % 4) == 0);
      else readCheck(int'($urandom % DEPTH), "R2 random read");
    end
    check("R3 final offset", curOffset, expOffset);
    for (int i = 0; i < DEPTH; i++) readCheck(i, "R7 final sweep of lines");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule